// File: doc/BRIEF.md
# Camera packet header decoder

This block sits at the front of a camera link receiver. It takes a 32-bit word stream in which each packet starts with a header word. It decodes that header into a data type, a virtual channel of up to four bits, and a 16-bit count. The count is the payload length of a long packet, or the data value of a short packet. A six-bit single-correct, double-detect check protects the 24 header data bits. The block repairs any single-bit error and refuses headers with a double-bit error.

After an accepted long-packet header, the block tracks the payload byte by byte. It forwards the words that carry payload bytes on a valid/ready output stream, with byte enables and an end marker. The two trailing check bytes of the payload are not verified here. They are captured into a sideband register and presented with a one-cycle strobe, so that a downstream stage can recompute them. The raw received header check byte is presented next to the decoded fields for the same purpose.

Back-pressure rules: the input is always ready between packets, since a header word is consumed in one cycle. During a payload, a word that carries payload bytes is consumed only when the output is ready, and the output valid follows the input valid combinationally. A word that holds nothing but check bytes is consumed at once. The sideband check value is not meaningful if the stream delivers fewer bytes than the header count announces.

Top module: `pkt_hdr_dec`

## Requirements
- R1: A header word is accepted when `in_valid` and `in_sop` are high between packets. One cycle later, `hdr_valid` pulses for one cycle, carrying the following fields:
  - `hdr_dt` = bits 5:0
  - base channel = bits 7:6
  - `hdr_wc` = bits 23:8, where byte 1 is the low byte
  - `hdr_ecc` = the raw bits 31:24
- R2: Check bits 29:24 form the check code. Check bit j is the XOR of every data bit i (bits 23:0) whose column has bit j set. The column for data bit i is the i-th value, in ascending order, among the 6-bit values of odd weight 3 or more. If exactly one of bits 29:0 is flipped, the fields are delivered corrected and `hdr_fix` pulses together with `hdr_valid`.
- R3: A header with two of bits 29:0 flipped produces no `hdr_valid`, and its payload words produce no output. It sets `err_dbl`, which stays high until reset.
- R4: A data type below 0x10 is a short packet. It has no payload words, and `hdr_long` is 0. Any other data type is long (`hdr_long`=1), and is followed by `hdr_wc` payload bytes and two check bytes, packed contiguously.
- R5: Bits 31:30 are extension channel bits and are not covered by the check code. With `vc_ext_en`=1 at header acceptance, `hdr_vc` = {bits 31:30, bits 7:6}. With `vc_ext_en`=0, the top two bits of `hdr_vc` are 0.
- R6: `hdr_embedded` is 1 exactly when the decoded data type is 0x12.
- R7: Only payload words that contain at least one payload byte produce an output beat. On each beat:
  - `out_data` equals the input word.
  - `out_keep[k]` marks lane k (bits 8k+7:8k) as a payload byte; the marked lanes are contiguous from lane 0.
  - `out_last` is 1 on the final beat.
- R8: After the word holding the second check byte is accepted, `crc_valid` pulses one cycle later, with `crc_rx` = {second byte, first byte}.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low. A word holding only check bytes is accepted without an output beat.
- R10: Words without `in_sop` outside a packet are discarded. Inside a long packet, `in_sop` is ignored and the word is treated as payload.
- R11: During and right after reset, `hdr_valid`, `hdr_fix`, `err_dbl`, `out_valid` and `crc_valid` are 0, and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | 32 | Input word; lane 0 is bits 7:0 |
| in_sop | input | 1 | Marks a header word |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with `in_valid` |
| vc_ext_en | input | 1 | Enables the two extension channel bits |
| hdr_valid | output | 1 | Decoded header strobe |
| hdr_dt | output | 6 | Data type |
| hdr_vc | output | 4 | Virtual channel |
| hdr_wc | output | 16 | Word count or short-packet data |
| hdr_long | output | 1 | Long-packet class |
| hdr_embedded | output | 1 | Embedded non-image data type |
| hdr_ecc | output | 8 | Raw received check byte |
| hdr_fix | output | 1 | Single-bit header correction strobe |
| err_dbl | output | 1 | Sticky double-bit header error |
| out_data | output | 32 | Payload word |
| out_keep | output | 4 | Payload byte enables |
| out_last | output | 1 | Final payload beat |
| out_valid | output | 1 | Payload beat valid |
| out_ready | input | 1 | Downstream ready |
| crc_valid | output | 1 | Payload check bytes strobe |
| crc_rx | output | 16 | Received payload check bytes |

## Verification
The hardest cases to reach from the ports are where the two check bytes split across a word boundary, or fill a word of their own, while the output is stalled. Such a word must be consumed without a beat while the previous one waits. The bench sends long packets with counts 0 through 4 and 7 and 10, under a pseudo-random `out_ready`. This walks the check bytes through every lane position. Headers are also sent with one or two chosen bits flipped, including a check bit, and then followed by a stray payload to show that dropped packets leave no output behind.

// File: rtl/pkt_hdr_pkg.sv
package pkt_hdr_pkg;
  localparam int WORD_BYTES = 4;
  localparam int WORD_W     = 8 * WORD_BYTES;
  localparam int DT_W       = 6;
  localparam int WC_W       = 16;
  localparam int CHK_W      = 6;
  localparam int PROT_W     = 24;
  localparam int CRC_W      = 16;

  // Column of the check matrix for protected bit idx: idx-th odd-weight (>=3) code.
  function automatic logic [CHK_W-1:0] chk_col(input int idx);
    int n;
    logic [CHK_W-1:0] r;
    n = 0;
    r = '0;
    for (int v = 0; v < (1 << CHK_W); v++) begin
      if (($countones(CHK_W'(v)) % 2 == 1) && ($countones(CHK_W'(v)) >= 3)) begin
        if (n == idx) r = CHK_W'(v);
        n++;
      end
    end
    return r;
  endfunction

  function automatic logic [CHK_W-1:0] chk_gen(input logic [PROT_W-1:0] d);
    logic [CHK_W-1:0] c;
    c = '0;
    for (int i = 0; i < PROT_W; i++)
      if (d[i]) c = c ^ chk_col(i);
    return c;
  endfunction
endpackage

// File: rtl/pkt_hdr_ecc.sv
module pkt_hdr_ecc
  import pkt_hdr_pkg::*;
(
  input  logic [PROT_W-1:0] raw,
  input  logic [CHK_W-1:0]  rx_chk,
  output logic [PROT_W-1:0] fixed,
  output logic              single,
  output logic              double
);
  logic [CHK_W-1:0] syn;
  logic             odd;

  assign syn    = chk_gen(raw) ^ rx_chk;
  assign odd    = ^syn;
  assign single = (syn != '0) && odd;
  assign double = (syn != '0) && !odd;

  for (genvar i = 0; i < PROT_W; i++) begin : g_fix
    assign fixed[i] = raw[i] ^ (syn == chk_col(i));
  end
endmodule

// File: rtl/pkt_hdr_pay.sv
module pkt_hdr_pay
  import pkt_hdr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [WC_W-1:0]       start_wc,
  input  logic [WORD_W-1:0]     in_data,
  input  logic                  in_valid,
  output logic                  in_ready,
  output logic                  busy,
  output logic [WORD_W-1:0]     out_data,
  output logic [WORD_BYTES-1:0] out_keep,
  output logic                  out_last,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic                  crc_valid,
  output logic [CRC_W-1:0]      crc_rx
);
  localparam int CNT_W = WC_W + 1;

  logic [CNT_W-1:0]      base;
  logic [WC_W-1:0]       wc_r;
  logic [CNT_W-1:0]      wc_x;
  logic                  has_pay, end_word, acc;
  logic [WORD_BYTES-1:0] hit_lo, hit_hi;
  logic [7:0]            crc_lo, crc_hi;

  assign wc_x     = {1'b0, wc_r};
  assign has_pay  = base < wc_x;
  assign out_last = (base + CNT_W'(WORD_BYTES)) >= wc_x;
  assign end_word = (base + CNT_W'(WORD_BYTES)) >= (wc_x + CNT_W'(2));
  assign in_ready = !has_pay || out_ready;
  assign out_valid = busy && in_valid && has_pay;
  assign out_data = in_data;
  assign acc      = busy && in_valid && in_ready;
  assign crc_rx   = {crc_hi, crc_lo};

  for (genvar k = 0; k < WORD_BYTES; k++) begin : g_lane
    assign out_keep[k] = (base + CNT_W'(k)) < wc_x;
    assign hit_lo[k]   = acc && ((base + CNT_W'(k)) == wc_x);
    assign hit_hi[k]   = acc && ((base + CNT_W'(k)) == (wc_x + CNT_W'(1)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      base      <= '0;
      wc_r      <= '0;
      crc_lo    <= '0;
      crc_hi    <= '0;
      crc_valid <= 1'b0;
    end else begin
      crc_valid <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        base <= '0;
        wc_r <= start_wc;
      end else if (acc) begin
        base <= base + CNT_W'(WORD_BYTES);
        for (int k = 0; k < WORD_BYTES; k++) begin
          if (hit_lo[k]) crc_lo <= in_data[8*k +: 8];
          if (hit_hi[k]) crc_hi <= in_data[8*k +: 8];
        end
        if (end_word) begin
          busy      <= 1'b0;
          crc_valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pkt_hdr_dec.sv
module pkt_hdr_dec
  import pkt_hdr_pkg::*;
#(
  parameter logic [DT_W-1:0] LONG_DT_MIN = 6'h10,
  parameter logic [DT_W-1:0] EMBED_DT    = 6'h12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [WORD_W-1:0]     in_data,
  input  logic                  in_sop,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic                  vc_ext_en,
  output logic                  hdr_valid,
  output logic [DT_W-1:0]       hdr_dt,
  output logic [3:0]            hdr_vc,
  output logic [WC_W-1:0]       hdr_wc,
  output logic                  hdr_long,
  output logic                  hdr_embedded,
  output logic [7:0]            hdr_ecc,
  output logic                  hdr_fix,
  output logic                  err_dbl,
  output logic [WORD_W-1:0]     out_data,
  output logic [WORD_BYTES-1:0] out_keep,
  output logic                  out_last,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic                  crc_valid,
  output logic [CRC_W-1:0]      crc_rx
);
  logic [PROT_W-1:0] prot_fix;
  logic              sgl, dbl, busy, pay_ready, hdr_acc, is_long, pay_start;
  logic [DT_W-1:0]   dt_fix;
  logic [1:0]        vc_base, vc_ext;
  logic [WC_W-1:0]   wc_fix;

  pkt_hdr_ecc u_ecc (
    .raw    (in_data[PROT_W-1:0]),
    .rx_chk (in_data[PROT_W +: CHK_W]),
    .fixed  (prot_fix),
    .single (sgl),
    .double (dbl)
  );

  assign dt_fix    = prot_fix[DT_W-1:0];
  assign vc_base   = prot_fix[7:6];
  assign wc_fix    = prot_fix[PROT_W-1:8];
  assign vc_ext    = in_data[WORD_W-1 -: 2];
  assign is_long   = dt_fix >= LONG_DT_MIN;
  assign in_ready  = busy ? pay_ready : 1'b1;
  assign hdr_acc   = in_valid && in_sop && !busy;
  assign pay_start = hdr_acc && !dbl && is_long;

  pkt_hdr_pay u_pay (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (pay_start),
    .start_wc  (wc_fix),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .in_ready  (pay_ready),
    .busy      (busy),
    .out_data  (out_data),
    .out_keep  (out_keep),
    .out_last  (out_last),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .crc_valid (crc_valid),
    .crc_rx    (crc_rx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_valid    <= 1'b0;
      hdr_fix      <= 1'b0;
      err_dbl      <= 1'b0;
      hdr_dt       <= '0;
      hdr_vc       <= '0;
      hdr_wc       <= '0;
      hdr_long     <= 1'b0;
      hdr_embedded <= 1'b0;
      hdr_ecc      <= '0;
    end else begin
      hdr_valid <= hdr_acc && !dbl;
      hdr_fix   <= hdr_acc && !dbl && sgl;
      if (hdr_acc && dbl) err_dbl <= 1'b1;
      if (hdr_acc && !dbl) begin
        hdr_dt       <= dt_fix;
        hdr_vc       <= {(vc_ext_en ? vc_ext : 2'b00), vc_base};
        hdr_wc       <= wc_fix;
        hdr_long     <= is_long;
        hdr_embedded <= (dt_fix == EMBED_DT);
        hdr_ecc      <= in_data[WORD_W-1 -: 8];
      end
    end
  end
endmodule

// File: rtl/pkt_hdr_dec_chk.sv
module pkt_hdr_dec_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       vc_ext_en,
  input logic       hdr_valid,
  input logic [3:0] hdr_vc,
  input logic       hdr_long,
  input logic       hdr_fix,
  input logic       err_dbl,
  input logic [3:0] out_keep,
  input logic       out_valid,
  input logic       out_ready,
  input logic       crc_valid
);
  AST_FIX_WITH_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_fix |-> hdr_valid); // R2
  AST_DBL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_dbl |=> err_dbl); // R3
  AST_SHORT_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && !hdr_long) |-> !out_valid); // R4
  AST_EXT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && !$past(vc_ext_en)) |-> (hdr_vc[3:2] == 2'b00)); // R5
  AST_KEEP_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_keep == 4'h1 || out_keep == 4'h3 || out_keep == 4'h7 || out_keep == 4'hF)); // R7
  AST_CRC_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    crc_valid |-> $past(in_valid && in_ready)); // R8
  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R9
endmodule

bind pkt_hdr_dec pkt_hdr_dec_chk u_chk (.*);

// File: tb/sim_pkt_hdr_dec.sv
`timescale 1ns/1ps
module sim_pkt_hdr_dec;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] in_data = '0;
  logic in_sop = 1'b0, in_valid = 1'b0, in_ready, vc_ext_en = 1'b1;
  logic hdr_valid, hdr_long, hdr_embedded, hdr_fix, err_dbl;
  logic [5:0] hdr_dt;
  logic [3:0] hdr_vc;
  logic [15:0] hdr_wc;
  logic [7:0] hdr_ecc;
  logic [31:0] out_data;
  logic [3:0] out_keep;
  logic out_last, out_valid, crc_valid;
  logic out_ready = 1'b1;
  logic [15:0] crc_rx;

  pkt_hdr_dec u0 (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_sop(in_sop), .in_valid(in_valid),
    .in_ready(in_ready), .vc_ext_en(vc_ext_en), .hdr_valid(hdr_valid), .hdr_dt(hdr_dt),
    .hdr_vc(hdr_vc), .hdr_wc(hdr_wc), .hdr_long(hdr_long), .hdr_embedded(hdr_embedded),
    .hdr_ecc(hdr_ecc), .hdr_fix(hdr_fix), .err_dbl(err_dbl), .out_data(out_data),
    .out_keep(out_keep), .out_last(out_last), .out_valid(out_valid), .out_ready(out_ready),
    .crc_valid(crc_valid), .crc_rx(crc_rx)
  );

  int checks = 0, errors = 0;
  logic [36:0] q_hdr[$];
  logic [36:0] q_beat[$];
  logic [15:0] q_crc[$];
  bit rnd_ready = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  localparam logic [5:0] COLS [24] = '{6'd7, 6'd11, 6'd13, 6'd14, 6'd19, 6'd21, 6'd22, 6'd25,
    6'd26, 6'd28, 6'd31, 6'd35, 6'd37, 6'd38, 6'd41, 6'd42, 6'd44, 6'd47, 6'd49, 6'd50,
    6'd52, 6'd55, 6'd56, 6'd59};

  function automatic logic [5:0] tb_chk(input logic [23:0] d);
    logic [5:0] c = '0;
    for (int i = 0; i < 24; i++) if (d[i]) c ^= COLS[i];
    return c;
  endfunction

  function automatic logic [7:0] pay_byte(input int seed, input int idx);
    return 8'(seed * 31 + idx * 7 + 5);
  endfunction

  task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = rnd_ready ? (lfsr[0] | lfsr[3]) : 1'b1;
  end

  // Monitor: compares outputs against the scoreboard queues.
  always @(negedge clk) begin
    if (rst_n) begin
      if (hdr_valid) begin
        logic [36:0] act, exp;
        act = {hdr_fix, hdr_ecc, hdr_embedded, hdr_long, hdr_wc, hdr_vc, hdr_dt};
        if (q_hdr.size() == 0) check(1'b0, "R1 R3 R10 unexpected header", act, 0);
        else begin
          exp = q_hdr.pop_front();
          check(act == exp, "R1 R2 R4 R5 R6 header fields", act, exp);
        end
      end
      if (out_valid && out_ready) begin
        logic [36:0] exp;
        logic [31:0] m;
        if (q_beat.size() == 0) check(1'b0, "R3 R4 R7 unexpected beat", {out_last, out_keep, out_data}, 0);
        else begin
          exp = q_beat.pop_front();
          for (int k = 0; k < 4; k++) m[8*k +: 8] = {8{exp[32+k]}};
          check({out_last, out_keep} == exp[36:32] && (out_data & m) == (exp[31:0] & m),
                "R7 payload beat", {out_last, out_keep, out_data & m}, {exp[36:32], exp[31:0] & m});
        end
      end
      if (out_valid && !out_ready) check(!in_ready, "R9 stall holds input", in_ready, 0);
      if (crc_valid) begin
        if (q_crc.size() == 0) check(1'b0, "R8 unexpected crc strobe", crc_rx, 0);
        else begin
          logic [15:0] e;
          e = q_crc.pop_front();
          check(crc_rx == e, "R8 crc sideband", crc_rx, e);
        end
      end
    end
  end

  task automatic push_word(input logic [31:0] d, input logic s);
    in_data = d; in_sop = s; in_valid = 1'b1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0; in_sop = 1'b0;
  endtask

  // Driver: queues expectations, then sends the packet words.
  task automatic send_pkt(input logic [5:0] dt, input logic [1:0] vcb, input logic [1:0] ext,
                          input logic [15:0] wc, input logic [31:0] flip, input bit en,
                          input int seed, input int sop_at);
    logic [23:0] d;
    logic [31:0] hw;
    logic [15:0] crc;
    bit lng, clean;
    int nw, n;
    d = {wc, vcb, dt};
    hw = {ext, tb_chk(d), d} ^ flip;
    vc_ext_en = en;
    lng = (dt >= 6'h10);
    clean = ($countones(flip) < 2);
    n = int'(wc);
    crc = 16'(seed * 977 + 3);
    if (clean) begin
      q_hdr.push_back({($countones(flip) == 1), hw[31:24], (dt == 6'h12), lng, wc,
                       (en ? ext : 2'b00), vcb, dt});
    end
    push_word(hw, 1'b1);
    if (lng) begin
      nw = (n + 2 + 3) / 4;
      if (clean) q_crc.push_back(crc);
      for (int w = 0; w < nw; w++) begin
        logic [31:0] word;
        logic [3:0] kp;
        for (int k = 0; k < 4; k++) begin
          int idx;
          idx = 4 * w + k;
          word[8*k +: 8] = (idx < n) ? pay_byte(seed, idx) :
                           (idx == n) ? crc[7:0] : (idx == n + 1) ? crc[15:8] : 8'h00;
          kp[k] = (idx < n);
        end
        if (clean && (4 * w < n)) q_beat.push_back({(4 * w + 4 >= n), kp, word});
        push_word(word, (w == sop_at));
      end
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check(!hdr_valid && !hdr_fix && !err_dbl && !out_valid && !crc_valid && in_ready,
          "R11 reset outputs", {hdr_valid, hdr_fix, err_dbl, out_valid, crc_valid, in_ready}, 6'b000001);
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    check(!hdr_valid && !err_dbl && !out_valid && in_ready, "R11 after reset",
          {hdr_valid, err_dbl, out_valid, in_ready}, 4'b0001);
    @(posedge clk); #1;

    send_pkt(6'h01, 2'd1, 2'd2, 16'hABCD, 32'h0, 1'b1, 1, -1);   // R4 short
    send_pkt(6'h2B, 2'd3, 2'd1, 16'd10, 32'h0, 1'b1, 2, -1);     // R7 long
    rnd_ready = 1'b1;
    send_pkt(6'h12, 2'd0, 2'd3, 16'd7, 32'h0, 1'b1, 3, -1);      // R6 embedded
    for (int c = 0; c <= 4; c++)                                 // R8 crc lane positions
      send_pkt(6'h2A, 2'(c), 2'd0, 16'(c), 32'h0, 1'b1, 10 + c, -1);
    push_word(32'h1234_5678, 1'b0);                              // R10 stray word
    send_pkt(6'h24, 2'd2, 2'd3, 16'd5, 32'h0, 1'b0, 20, -1);     // R5 extension off
    send_pkt(6'h2C, 2'd1, 2'd2, 16'd6, 32'h0000_0001, 1'b1, 21, -1); // R2 bit 0
    send_pkt(6'h2C, 2'd2, 2'd1, 16'd9, 32'h0000_2000, 1'b1, 22, -1); // R2 bit 13
    send_pkt(6'h05, 2'd3, 2'd0, 16'h5A5A, 32'h0080_0000, 1'b1, 23, -1); // R2 bit 23
    send_pkt(6'h31, 2'd0, 2'd1, 16'd3, 32'h0400_0000, 1'b1, 24, -1); // R2 check bit
    send_pkt(6'h2B, 2'd1, 2'd0, 16'd12, 32'h0, 1'b1, 25, 1);     // R10 sop inside payload
    repeat (6) @(negedge clk);
    check(err_dbl == 1'b0, "R3 no error before double", err_dbl, 0);
    @(posedge clk); #1;
    send_pkt(6'h2B, 2'd1, 2'd1, 16'd8, 32'h0002_0004, 1'b1, 26, -1); // R3 double error
    repeat (4) @(negedge clk);
    check(err_dbl == 1'b1, "R3 sticky set", err_dbl, 1);
    @(posedge clk); #1;
    send_pkt(6'h1E, 2'd2, 2'd2, 16'd4, 32'h0, 1'b1, 27, -1);
    rnd_ready = 1'b0;
    for (int t = 0; t < 200; t++) begin
      @(negedge clk);
      if (q_hdr.size() == 0 && q_beat.size() == 0 && q_crc.size() == 0) break;
    end
    repeat (4) @(negedge clk);
    check(err_dbl == 1'b1, "R3 sticky held", err_dbl, 1);
    check(q_hdr.size() == 0, "R1 headers drained", q_hdr.size(), 0);
    check(q_beat.size() == 0, "R7 beats drained", q_beat.size(), 0);
    check(q_crc.size() == 0, "R8 crc drained", q_crc.size(), 0);
    finish_run();
  end
endmodule